// File: doc/BRIEF.md
# Dual Display FIFO Fill Controller

This block keeps two display pixel queues topped up from memory: one for a flat panel (LCD) and one for a VGA output. Memory is reached through a request/data handshake of the kind a DMA engine serves. A request is held high until a fixed burst of words has been taken. Each display drains its own queue through a pop port. The TFT panel timing takes one word per pixel clock.

Two fill modes exist. In split mode each queue has its own request channel and refills when it alone has room. In shared mode, used when both screens show the same image, only the LCD channel fetches. Every word it accepts lands in both queues in the same cycle, which halves the memory traffic. That shared request is raised only when both queues have room for a whole burst.

A small control register holds both display enables, the mode bit and two sticky underflow flags. The underflow flags exist because the two queue levels can drift apart in shared mode. The display whose queue is fuller then holds back the refill that the emptier one needs.

Top module: `dual_disp_fill`

## Requirements
- R1: Control register bits are: bit 0 LCD enable, bit 1 VGA enable, bit 2 mode (0 split, 1 shared), bit 3 LCD underflow, bit 4 VGA underflow. One write sets both enables together, and the register reads back on `cfg_rdata` the cycle after the write.
- R2: In split mode each channel raises its request one cycle after its display is enabled with at least 4 free words, without regard to the other display.
- R3: A raised request stays high until 4 words have been accepted on that channel, then drops for at least one cycle. Words presented while the request is low are not stored, so a queue of depth 16 never overflows.
- R4: In shared mode the VGA request stays low. The LCD request rises only when both displays are enabled and both queues have at least 4 free words.
- R5: In shared mode each word accepted on the LCD channel is written into both queues in the same cycle. VGA channel data is ignored.
- R6: Each pop port shows the oldest stored word while not empty, and popping on consecutive cycles returns the words in write order, one per cycle.
- R7: An underflow flag is set when its display is enabled and a pop is attempted on its empty queue. It stays set with no pop activity and with writes that carry 0 in its bit. No flag is set by a pop to a disabled display.
- R8: Writing 1 to an underflow bit clears that flag.
- R9: A display whose enable is 0 has its queue emptied one cycle later, and the queue stays empty until refilled after re-enabling.
- R10: A write to the mode bit takes effect only while both enables are currently 0. Otherwise the mode bit keeps its old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 5 | Control register write data |
| cfg_rdata | output | 5 | Control register contents |
| lcd_req | output | 1 | LCD (or shared) fill request |
| lcd_wvalid | input | 1 | Word valid on LCD fill channel |
| lcd_wdata | input | DW | Word on LCD fill channel |
| vga_req | output | 1 | VGA fill request |
| vga_wvalid | input | 1 | Word valid on VGA fill channel |
| vga_wdata | input | DW | Word on VGA fill channel |
| lcd_pop | input | 1 | LCD pixel read strobe |
| lcd_rdata | output | DW | Oldest LCD queue word |
| lcd_empty | output | 1 | LCD queue empty |
| vga_pop | input | 1 | VGA pixel read strobe |
| vga_rdata | output | DW | Oldest VGA queue word |
| vga_empty | output | 1 | VGA queue empty |

## Verification
A wrong fill level shows up directly at the request pins. A request that is counted too early or too late changes the burst length, so a stray or missing word shows within one burst. A wrong room test raises the shared request while one queue is full, or keeps it low once both have drained. Write-side mistakes reach the pop data within the depth of the queue: a word lost, duplicated or sent to only one queue in shared mode. A wrong mode or flag state reads back on `cfg_rdata` in the cycle after the write that caused it.

// File: rtl/disp_fill_pkg.sv
package disp_fill_pkg;

    localparam int unsigned CFG_W       = 5;
    localparam int unsigned BIT_LCD_EN  = 0;
    localparam int unsigned BIT_VGA_EN  = 1;
    localparam int unsigned BIT_MODE    = 2;
    localparam int unsigned BIT_LCD_UF  = 3;
    localparam int unsigned BIT_VGA_UF  = 4;

    localparam int unsigned N_DISP = 2;
    localparam int unsigned IDX_LCD = 0;
    localparam int unsigned IDX_VGA = 1;

    typedef enum logic {
        FILL_SPLIT  = 1'b0,
        FILL_SHARED = 1'b1
    } fill_mode_e;

    typedef struct packed {
        logic       vga_uf;
        logic       lcd_uf;
        fill_mode_e mode;
        logic       vga_en;
        logic       lcd_en;
    } ctrl_t;

    function automatic ctrl_t ctrl_from_bits(input logic [CFG_W-1:0] b);
        ctrl_t c;
        c.lcd_en = b[BIT_LCD_EN];
        c.vga_en = b[BIT_VGA_EN];
        c.mode   = fill_mode_e'(b[BIT_MODE]);
        c.lcd_uf = b[BIT_LCD_UF];
        c.vga_uf = b[BIT_VGA_UF];
        return c;
    endfunction

    function automatic logic [CFG_W-1:0] ctrl_to_bits(input ctrl_t c);
        logic [CFG_W-1:0] b;
        b = '0;
        b[BIT_LCD_EN] = c.lcd_en;
        b[BIT_VGA_EN] = c.vga_en;
        b[BIT_MODE]   = c.mode;
        b[BIT_LCD_UF] = c.lcd_uf;
        b[BIT_VGA_UF] = c.vga_uf;
        return b;
    endfunction

endpackage

// File: rtl/pix_fifo.sv
module pix_fifo #(
    parameter int unsigned DW    = 24,
    parameter int unsigned DEPTH = 16,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    input  logic          pop,
    output logic [DW-1:0] rdata,
    output logic          empty,
    output logic          full,
    output logic [LW-1:0] free
);
    localparam logic [LW-1:0] DEPTH_LV = LW'(DEPTH);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic [LW-1:0] level;
    logic          do_push, do_pop;

    assign empty   = (level == '0);
    assign full    = (level == DEPTH_LV);
    assign free    = DEPTH_LV - level;
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rptr];

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wptr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wptr  <= '0;
            rptr  <= '0;
            level <= '0;
        end else begin
            if (do_push) wptr <= wptr + 1'b1;
            if (do_pop)  rptr <= rptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

endmodule

// File: rtl/burst_req.sv
module burst_req #(
    parameter int unsigned BURST = 4,
    localparam int unsigned CW   = (BURST > 1) ? $clog2(BURST) : 1
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic room_ok,
    input  logic wvalid,
    output logic req,
    output logic take
);
    localparam logic [CW-1:0] LAST = CW'(BURST - 1);

    logic [CW-1:0] taken;

    assign take = req && wvalid && enable;

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            req   <= 1'b0;
            taken <= '0;
        end else if (req) begin
            if (take) begin
                if (taken == LAST) begin
                    req   <= 1'b0;
                    taken <= '0;
                end else begin
                    taken <= taken + 1'b1;
                end
            end
        end else if (room_ok) begin
            req   <= 1'b1;
            taken <= '0;
        end
    end

endmodule

// File: rtl/dual_disp_fill.sv
module dual_disp_fill
    import disp_fill_pkg::*;
#(
    parameter int unsigned DW    = 24,
    parameter int unsigned DEPTH = 16,
    parameter int unsigned BURST = 4,
    localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_rdata,
    output logic             lcd_req,
    input  logic             lcd_wvalid,
    input  logic [DW-1:0]    lcd_wdata,
    output logic             vga_req,
    input  logic             vga_wvalid,
    input  logic [DW-1:0]    vga_wdata,
    input  logic             lcd_pop,
    output logic [DW-1:0]    lcd_rdata,
    output logic             lcd_empty,
    input  logic             vga_pop,
    output logic [DW-1:0]    vga_rdata,
    output logic             vga_empty
);
    localparam logic [LW-1:0] BURST_LV = LW'(BURST);

    ctrl_t ctrl_q, wr_c;
    logic  shared;

    logic [N_DISP-1:0]         en, push, popi, empty, full, room, ch_en, ch_room;
    logic [N_DISP-1:0]         ch_valid, ch_req, ch_take, uf_set;
    logic [N_DISP-1:0][DW-1:0] wd, rd;
    logic [N_DISP-1:0][LW-1:0] free;

    assign shared = (ctrl_q.mode == FILL_SHARED);
    assign en     = {ctrl_q.vga_en, ctrl_q.lcd_en};
    assign wr_c   = ctrl_from_bits(cfg_wdata);

    // Control register: enables, mode guarded by both enables off, W1C flags
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '{vga_uf: 1'b0, lcd_uf: 1'b0, mode: FILL_SPLIT,
                        vga_en: 1'b0, lcd_en: 1'b0};
        end else begin
            if (cfg_we) begin
                ctrl_q.lcd_en <= wr_c.lcd_en;
                ctrl_q.vga_en <= wr_c.vga_en;
                if (!ctrl_q.lcd_en && !ctrl_q.vga_en) begin
                    ctrl_q.mode <= wr_c.mode;
                end
            end
            ctrl_q.lcd_uf <= uf_set[IDX_LCD] |
                             (ctrl_q.lcd_uf & ~(cfg_we & wr_c.lcd_uf));
            ctrl_q.vga_uf <= uf_set[IDX_VGA] |
                             (ctrl_q.vga_uf & ~(cfg_we & wr_c.vga_uf));
        end
    end

    assign cfg_rdata = ctrl_to_bits(ctrl_q);

    // Channel steering: in shared mode channel 0 serves both queues
    always_comb begin
        ch_en[IDX_LCD]   = shared ? (en[IDX_LCD] & en[IDX_VGA]) : en[IDX_LCD];
        ch_room[IDX_LCD] = shared ? (room[IDX_LCD] & room[IDX_VGA]) : room[IDX_LCD];
        ch_en[IDX_VGA]   = shared ? 1'b0 : en[IDX_VGA];
        ch_room[IDX_VGA] = room[IDX_VGA];
        ch_valid         = {vga_wvalid, lcd_wvalid};

        push[IDX_LCD] = ch_take[IDX_LCD];
        wd[IDX_LCD]   = lcd_wdata;
        push[IDX_VGA] = shared ? ch_take[IDX_LCD] : ch_take[IDX_VGA];
        wd[IDX_VGA]   = shared ? lcd_wdata : vga_wdata;
    end

    assign popi = {vga_pop, lcd_pop};

    for (genvar g = 0; g < N_DISP; g++) begin : g_disp
        assign room[g]   = (free[g] >= BURST_LV);
        assign uf_set[g] = popi[g] & empty[g] & en[g];

        pix_fifo #(.DW(DW), .DEPTH(DEPTH)) i_fifo (
            .clk   (clk),
            .rst   (rst),
            .flush (!en[g]),
            .push  (push[g]),
            .wdata (wd[g]),
            .pop   (popi[g] & en[g]),
            .rdata (rd[g]),
            .empty (empty[g]),
            .full  (full[g]),
            .free  (free[g])
        );

        burst_req #(.BURST(BURST)) i_req (
            .clk     (clk),
            .rst     (rst),
            .enable  (ch_en[g]),
            .room_ok (ch_room[g]),
            .wvalid  (ch_valid[g]),
            .req     (ch_req[g]),
            .take    (ch_take[g])
        );
    end

    assign lcd_req   = ch_req[IDX_LCD];
    assign vga_req   = ch_req[IDX_VGA];
    assign lcd_rdata = rd[IDX_LCD];
    assign vga_rdata = rd[IDX_VGA];
    assign lcd_empty = empty[IDX_LCD];
    assign vga_empty = empty[IDX_VGA];

endmodule

// File: rtl/disp_fill_chk.sv
module disp_fill_chk
    import disp_fill_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned BURST = 4,
    localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      shared,
    input logic [N_DISP-1:0]         en,
    input logic [N_DISP-1:0]         push,
    input logic [N_DISP-1:0]         full,
    input logic [N_DISP-1:0]         empty,
    input logic [N_DISP-1:0][LW-1:0] free,
    input logic                      lcd_req,
    input logic                      vga_req,
    input logic                      cfg_we,
    input logic [CFG_W-1:0]          cfg_wdata,
    input logic [CFG_W-1:0]          cfg_rdata
);
    localparam logic [LW-1:0] BURST_LV = LW'(BURST);

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        |push |-> ((push & full) == '0));

    assert_shared_room_R4: assert property (@(posedge clk) disable iff (rst)
        (shared && $rose(lcd_req)) |->
            (free[IDX_LCD] >= BURST_LV && free[IDX_VGA] >= BURST_LV));

    assert_shared_vga_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        shared |-> !vga_req);

    assert_dual_write_R5: assert property (@(posedge clk) disable iff (rst)
        (shared && push[IDX_LCD]) |-> push[IDX_VGA]);

    assert_uf_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (cfg_rdata[BIT_LCD_UF] && !(cfg_we && cfg_wdata[BIT_LCD_UF]))
            |=> cfg_rdata[BIT_LCD_UF]);

    assert_flush_R9: assert property (@(posedge clk) disable iff (rst)
        !en[IDX_LCD] |=> empty[IDX_LCD]);

    assert_mode_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (|en) |=> (cfg_rdata[BIT_MODE] == $past(cfg_rdata[BIT_MODE])));

endmodule

bind dual_disp_fill disp_fill_chk #(.DEPTH(DEPTH), .BURST(BURST)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .shared    (shared),
    .en        (en),
    .push      (push),
    .full      (full),
    .empty     (empty),
    .free      (free),
    .lcd_req   (lcd_req),
    .vga_req   (vga_req),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata)
);

// File: tb/test_dual_disp_fill.sv
`timescale 1ns/1ps
module test_dual_disp_fill;
    localparam int DW = 24;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_we = 1'b0;
    logic [4:0]    cfg_wdata = '0;
    logic [4:0]    cfg_rdata;
    logic          lcd_req, vga_req;
    logic          lcd_wvalid = 1'b0, vga_wvalid = 1'b0;
    logic [DW-1:0] lcd_wdata = '0, vga_wdata = '0;
    logic          lcd_pop = 1'b0, vga_pop = 1'b0;
    logic [DW-1:0] lcd_rdata, vga_rdata;
    logic          lcd_empty, vga_empty;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    dual_disp_fill #(.DW(DW), .DEPTH(16), .BURST(4)) i_dual_disp_fill (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .lcd_req(lcd_req), .lcd_wvalid(lcd_wvalid), .lcd_wdata(lcd_wdata),
        .vga_req(vga_req), .vga_wvalid(vga_wvalid), .vga_wdata(vga_wdata),
        .lcd_pop(lcd_pop), .lcd_rdata(lcd_rdata), .lcd_empty(lcd_empty),
        .vga_pop(vga_pop), .vga_rdata(vga_rdata), .vga_empty(vga_empty)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    task automatic cfg_write(input logic [4:0] v);
        cfg_we = 1'b1;
        cfg_wdata = v;
        tick();
        cfg_we = 1'b0;
        cfg_wdata = '0;
    endtask

    task automatic lcd_burst(input int base);
        int waited = 0;
        while (!lcd_req && waited < 20) begin
            tick();
            waited++;
        end
        for (int i = 0; i < 4; i++) begin
            lcd_wvalid = 1'b1;
            lcd_wdata  = DW'(base + i);
            tick();
        end
        lcd_wvalid = 1'b0;
    endtask

    task automatic t_reset();
        check("R1", "reset cfg", 32'(cfg_rdata), 32'h0);
        check("R2", "reset lcd_req", 32'(lcd_req), 32'h0);
        check("R2", "reset vga_req", 32'(vga_req), 32'h0);
        check("R9", "reset empties", 32'({lcd_empty, vga_empty}), 32'h3);
    endtask

    task automatic t_split();
        cfg_write(5'b00001);
        check("R1", "readback lcd only", 32'(cfg_rdata), 32'h01);
        tick();
        check("R2", "lcd_req up", 32'(lcd_req), 32'h1);
        check("R2", "vga_req idle", 32'(vga_req), 32'h0);
        for (int i = 0; i < 5; i++) begin
            lcd_wvalid = 1'b1;
            lcd_wdata  = DW'(32'h100 + i);
            tick();
            if (i == 3) check("R3", "req drops after burst", 32'(lcd_req), 32'h0);
        end
        lcd_wvalid = 1'b0;
        for (int i = 0; i < 4; i++) begin
            check("R6", "lcd pop order", 32'(lcd_rdata), 32'h100 + i);
            lcd_pop = 1'b1;
            tick();
        end
        lcd_pop = 1'b0;
        check("R3", "fifth word not stored", 32'(lcd_empty), 32'h1);
        cfg_write(5'b00011);
        check("R1", "both enables in one write", 32'(cfg_rdata), 32'h03);
        tick();
        check("R2", "vga_req up", 32'(vga_req), 32'h1);
        check("R2", "lcd_req still up", 32'(lcd_req), 32'h1);
        cfg_write(5'b00000);
        tick();
        check("R9", "reqs drop when disabled", 32'({lcd_req, vga_req}), 32'h0);
    endtask

    task automatic t_flush();
        cfg_write(5'b00001);
        lcd_burst(32'h300);
        check("R9", "lcd holds data", 32'(lcd_empty), 32'h0);
        cfg_write(5'b00000);
        tick();
        check("R9", "lcd flushed", 32'(lcd_empty), 32'h1);
        cfg_write(5'b00001);
        check("R9", "stays empty on re-enable", 32'(lcd_empty), 32'h1);
        cfg_write(5'b00000);
        tick();
    endtask

    task automatic t_shared();
        cfg_write(5'b00111);
        check("R1", "shared readback", 32'(cfg_rdata), 32'h07);
        tick();
        check("R4", "shared lcd_req up", 32'(lcd_req), 32'h1);
        check("R4", "shared vga_req low", 32'(vga_req), 32'h0);
        for (int i = 0; i < 4; i++) begin
            lcd_wvalid = 1'b1;
            lcd_wdata  = DW'(32'h200 + i);
            vga_wvalid = 1'b1;
            vga_wdata  = DW'(32'h900 + i);
            tick();
        end
        lcd_wvalid = 1'b0;
        vga_wvalid = 1'b0;
        for (int i = 0; i < 4; i++) begin
            check("R5", "lcd copy", 32'(lcd_rdata), 32'h200 + i);
            check("R5", "vga copy", 32'(vga_rdata), 32'h200 + i);
            lcd_pop = 1'b1;
            vga_pop = 1'b1;
            tick();
        end
        lcd_pop = 1'b0;
        vga_pop = 1'b0;
        check("R5", "both drained", 32'({lcd_empty, vga_empty}), 32'h3);
        for (int b = 0; b < 4; b++) lcd_burst(32'h400 + 16 * b);
        tick();
        tick();
        check("R4", "no req when full", 32'(lcd_req), 32'h0);
        for (int i = 0; i < 4; i++) begin
            vga_pop = 1'b1;
            tick();
        end
        vga_pop = 1'b0;
        tick();
        tick();
        tick();
        check("R4", "no req with lcd full", 32'(lcd_req), 32'h0);
        for (int i = 0; i < 4; i++) begin
            lcd_pop = 1'b1;
            tick();
        end
        lcd_pop = 1'b0;
        tick();
        check("R4", "req once both have room", 32'(lcd_req), 32'h1);
        cfg_write(5'b00000);
        cfg_write(5'b00101);
        tick();
        tick();
        check("R4", "shared needs both enabled", 32'(lcd_req), 32'h0);
    endtask

    task automatic t_mode_guard();
        cfg_write(5'b00001);
        check("R10", "mode write ignored", 32'(cfg_rdata[2]), 32'h1);
        cfg_write(5'b00000);
        cfg_write(5'b00001);
        check("R10", "mode write accepted", 32'(cfg_rdata[2]), 32'h0);
        tick();
        check("R2", "split lcd_req", 32'(lcd_req), 32'h1);
    endtask

    task automatic t_underflow();
        vga_pop = 1'b1;
        tick();
        vga_pop = 1'b0;
        check("R7", "no flag on disabled pop", 32'(cfg_rdata[4]), 32'h0);
        lcd_pop = 1'b1;
        tick();
        lcd_pop = 1'b0;
        check("R7", "lcd flag set", 32'(cfg_rdata[3]), 32'h1);
        tick();
        tick();
        check("R7", "lcd flag sticky", 32'(cfg_rdata[3]), 32'h1);
        cfg_write(5'b00001);
        check("R7", "zero write keeps flag", 32'(cfg_rdata[3]), 32'h1);
        cfg_write(5'b01001);
        check("R8", "w1c clears flag", 32'(cfg_rdata[3]), 32'h0);
        check("R8", "enable kept", 32'(cfg_rdata[0]), 32'h1);
    endtask

    initial begin
        tick();
        tick();
        tick();
        rst = 1'b0;
        t_reset();
        t_split();
        t_flush();
        t_shared();
        t_mode_guard();
        t_underflow();
        summary();
        $finish;
    end

    initial begin
        #100000;
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

endmodule